// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps time as a free-running 32-bit count of seconds. An external one-pulse-per-second tick advances the count while counting is enabled. Software reaches every register through a simple byte-wide bus with an address, write data, a write strobe and combinational read data. It also programs a compare value and receives a level interrupt when the count reaches that value.

A new time is written one byte at a time. The three upper bytes are only staged in holding registers. Writing the lowest byte copies all four bytes into the counter in one step. The live count is read byte by byte with no snapshot latch, so a carry between byte reads can tear a multi-byte read. Software is expected to detect this by re-reading byte 0.

The counter enable and the alarm enable are two independent bits of one control register. The pending-alarm status bit sits in a second control register and is cleared by software.

Top module: `secs_rtc`

## Requirements
- R1: After reset, every readable register returns 0x00, counting and the alarm are both disabled, and the interrupt output is 0.
- R2: Control register bit 7 (address 0) enables counting. With it at 1, each cycle with the tick input high adds 1 to the count. With it at 0, ticks are ignored and the count holds.
- R3: Addresses 6 to 9 return the live count, least significant byte at address 6. Each byte reflects the counter at the moment of the read, with no latching.
- R4: Writes to addresses 3, 4 and 5 stage count bytes 1, 2 and 3 and leave the count unchanged. A write to address 2 loads the counter with {staged byte 3, staged byte 2, staged byte 1, written byte} on the following edge. If a tick arrives in the same cycle as that write, the load wins and the tick is dropped.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000 and raises no flag of its own.
- R6: In the control register, bit 7 (count enable) and bit 1 (alarm enable) are stored independently from the same write. Every other control bit reads back as 0.
- R7: Addresses 10 to 13 hold the 32-bit alarm compare value, least significant byte at address 10, readable and writable. Writing zeros to all four bytes leaves a compare value of 0.
- R8: The alarm status (address 1, bit 0) sets on a cycle where a tick increments the count to a value equal to the compare value while the alarm enable is 1. A load that produces the compare value does not set it. A match while the alarm enable is 0 does not set it.
- R9: Writing address 1 with bit 0 equal to 0 clears the alarm status. Writing bit 0 equal to 1 has no effect. When a new match and a clear fall in the same cycle, the status ends up set.
- R10: The interrupt output is a level equal to the alarm status AND the alarm enable bit. Clearing the enable drops the interrupt without clearing the status.
- R11: Addresses 14 and 15 and the load window (2 to 5) read as 0x00, and writes to the live-count window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second, that advances the count |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a tick and a load commit. The bench writes the low load byte in the same cycle as a tick and expects exactly the staged value afterwards, with no extra increment.

The second pair is an alarm match and a software clear of the status. The bench arranges a tick that reaches the compare value while writing 0 to the status bit, and expects the status and interrupt to remain set.

A behavioural model advanced on every edge is compared with the interrupt and the read data on every cycle, so both collisions are also judged against the model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W          = 8;
    localparam int CTRL_CNT_EN_BIT = 7;
    localparam int CTRL_ALM_EN_BIT = 1;
    localparam int ALM2_STAT_BIT   = 0;
    localparam int ADDR_CTRL       = 0;
    localparam int ADDR_ALM2       = 1;
    localparam int ADDR_LOAD_BASE  = 2;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_ALM2,
        RG_LOAD,
        RG_LIVE,
        RG_CMP,
        RG_NONE
    } rtc_region_e;

    typedef struct packed {
        logic cnt_en;
        logic alm_en;
    } rtc_ctrl_t;

    typedef struct packed {
        rtc_region_e region;
        logic [7:0]  idx;
    } rtc_decode_t;

    // Map a bus address to a register region and a byte index within it.
    function automatic rtc_decode_t decode_addr(input int unsigned a, input int unsigned nb);
        rtc_decode_t d;
        int unsigned live_base;
        int unsigned cmp_base;
        live_base = ADDR_LOAD_BASE + nb;
        cmp_base  = ADDR_LOAD_BASE + 2 * nb;
        d.region  = RG_NONE;
        d.idx     = '0;
        if (a == ADDR_CTRL) begin
            d.region = RG_CTRL;
        end else if (a == ADDR_ALM2) begin
            d.region = RG_ALM2;
        end else if (a >= ADDR_LOAD_BASE && a < live_base) begin
            d.region = RG_LOAD;
            d.idx    = 8'(a - ADDR_LOAD_BASE);
        end else if (a >= live_base && a < cmp_base) begin
            d.region = RG_LIVE;
            d.idx    = 8'(a - live_base);
        end else if (a >= cmp_base && a < cmp_base + nb) begin
            d.region = RG_CMP;
            d.idx    = 8'(a - cmp_base);
        end
        return d;
    endfunction

endpackage

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             step
);

    // A load in the same cycle as a tick takes priority; the tick is lost.
    assign step = enable && tick && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= count + CNT_W'(1);
        end
    end

    assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
        step |=> count == $past(count) + CNT_W'(1));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !(enable && tick)) |=> $stable(count));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step && count == {CNT_W{1'b1}}) |=> count == '0);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             alm_en,
    input  logic             clr,
    output logic             status,
    output logic             irq
);

    logic [CNT_W-1:0] next_count;
    logic             match;

    assign next_count = count + CNT_W'(1);
    assign match      = step && alm_en && (next_count == cmp_val);

    // A new match beats a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (match) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

    assign irq = status && alm_en;

    assert_rise_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> !$rose(status));

    assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!alm_en && !status) |=> !status);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !step) |=> !status);

    assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
        !alm_en |-> !irq);

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int ADDR_W = 4,
    localparam int CNT_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    output rtc_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              load_pulse,
    output logic [CNT_W-1:0]  load_val,
    output logic              status_clr,
    output logic [BYTE_W-1:0] rdata
);

    rtc_decode_t dec;
    assign dec = decode_addr(int'(addr), NBYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && dec.region == RG_CTRL) begin
            ctrl.cnt_en <= wdata[CTRL_CNT_EN_BIT];
            ctrl.alm_en <= wdata[CTRL_ALM_EN_BIT];
        end
    end

    assign load_pulse = we && dec.region == RG_LOAD && dec.idx == 8'd0;
    assign status_clr = we && dec.region == RG_ALM2 && !wdata[ALM2_STAT_BIT];

    assign load_val[BYTE_W-1:0] = wdata;

    for (genvar b = 1; b < NBYTES; b++) begin : g_stage
        logic [BYTE_W-1:0] stage_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
            end else if (we && dec.region == RG_LOAD && dec.idx == 8'(b)) begin
                stage_q <= wdata;
            end
        end
        assign load_val[b*BYTE_W +: BYTE_W] = stage_q;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_cmp
        logic [BYTE_W-1:0] cmp_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q <= '0;
            end else if (we && dec.region == RG_CMP && dec.idx == 8'(b)) begin
                cmp_q <= wdata;
            end
        end
        assign cmp_val[b*BYTE_W +: BYTE_W] = cmp_q;
    end

    always_comb begin
        rdata = '0;
        case (dec.region)
            RG_CTRL: begin
                rdata[CTRL_CNT_EN_BIT] = ctrl.cnt_en;
                rdata[CTRL_ALM_EN_BIT] = ctrl.alm_en;
            end
            RG_ALM2: rdata[ALM2_STAT_BIT] = status;
            RG_LIVE: begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (dec.idx == 8'(b)) rdata = count[b*BYTE_W +: BYTE_W];
                end
            end
            RG_CMP: begin
                for (int b = 0; b < NBYTES; b++) begin
                    if (dec.idx == 8'(b)) rdata = cmp_val[b*BYTE_W +: BYTE_W];
                end
            end
            default: rdata = '0;
        endcase
    end

    assert_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
        (we && dec.region == RG_CTRL) |=> ctrl.alm_en == $past(wdata[CTRL_ALM_EN_BIT]));

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int ADDR_W = 4,
    localparam int CNT_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              alarm_irq
);

    rtc_ctrl_t        ctrl;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] load_val;
    logic             load_pulse;
    logic             status_clr;
    logic             status;
    logic             step;

    rtc_bus_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .we         (bus_we),
        .count      (count),
        .status     (status),
        .ctrl       (ctrl),
        .cmp_val    (cmp_val),
        .load_pulse (load_pulse),
        .load_val   (load_val),
        .status_clr (status_clr),
        .rdata      (bus_rdata)
    );

    rtc_seconds_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .enable   (ctrl.cnt_en),
        .load     (load_pulse),
        .load_val (load_val),
        .count    (count),
        .step     (step)
    );

    rtc_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .count   (count),
        .cmp_val (cmp_val),
        .alm_en  (ctrl.alm_en),
        .clr     (status_clr),
        .status  (status),
        .irq     (alarm_irq)
    );

    assert_load_only_R8: assert property (@(posedge clk) disable iff (rst)
        (load_pulse && !status) |=> !status);

endmodule

// File: tb/secs_rtc_test.sv
`timescale 1ns/100ps
module secs_rtc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    secs_rtc uut (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick_1hz),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // Behavioural reference model
    logic [31:0] m_cnt, m_cmp;
    logic [7:0]  m_stage [1:3];
    bit          m_cen, m_aen, m_st;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_cen = 0; m_aen = 0; m_st = 0;
            for (int i = 1; i < 4; i++) m_stage[i] = 0;
        end else begin
            bit commit, incr, hit, clr;
            commit = bus_we && bus_addr == 2;
            incr   = m_cen && tick_1hz && !commit;
            hit    = incr && m_aen && (m_cnt + 1 == m_cmp);
            clr    = bus_we && bus_addr == 1 && !bus_wdata[0];
            if (hit) m_st = 1; else if (clr) m_st = 0;
            if (commit) m_cnt = {m_stage[3], m_stage[2], m_stage[1], bus_wdata};
            else if (incr) m_cnt = m_cnt + 1;
            if (bus_we) begin
                if (bus_addr == 0) begin m_cen = bus_wdata[7]; m_aen = bus_wdata[1]; end
                if (bus_addr >= 3 && bus_addr <= 5) m_stage[bus_addr - 2] = bus_wdata;
                if (bus_addr >= 10 && bus_addr <= 13) m_cmp[(bus_addr - 10) * 8 +: 8] = bus_wdata;
            end
        end
    end

    function automatic logic [7:0] mread(input int a);
        if (a == 0) return {m_cen, 5'b0, m_aen, 1'b0};
        if (a == 1) return {7'b0, m_st};
        if (a >= 6 && a <= 9) return m_cnt[(a - 6) * 8 +: 8];
        if (a >= 10 && a <= 13) return m_cmp[(a - 10) * 8 +: 8];
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(alarm_irq == (m_st && m_aen), "R10 irq vs model", 32'(alarm_irq), 32'(m_st && m_aen));
            chk(bus_rdata == mread(int'(bus_addr)), "R3 R11 read vs model", 32'(bus_rdata), 32'(mread(int'(bus_addr))));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit tk = 0);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_1hz = tk;
        @(posedge clk); #1;
        bus_we = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1;
            @(posedge clk); #1;
            tick_1hz = 1'b0;
        end
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; #0.2;
        chk(bus_rdata == exp, tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic rd32chk(input logic [3:0] base, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            bus_addr = base + 4'(i); #0.2;
            v[i*8 +: 8] = bus_rdata;
        end
        chk(v == exp, tag, v, exp);
    endtask

    task automatic load32(input logic [31:0] v, input bit tk = 0);
        wr(2, 8'h00);
        wr(3, v[15:8]); wr(4, v[23:16]); wr(5, v[31:24]);
        wr(2, v[7:0], tk);
    endtask

    task automatic setcmp(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(4'(10 + i), v[i*8 +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 16; a++) rdchk(4'(a), 8'h00, "R1 reset read");
        chk(alarm_irq == 1'b0, "R1 reset irq", 32'(alarm_irq), 0);

        // R2 ticks ignored while disabled
        tick(3);
        rd32chk(6, 32'h0, "R2 hold when disabled");

        // R4 staging does not move the count, low byte commits
        wr(2, 8'h00); wr(3, 8'h12); wr(4, 8'h34); wr(5, 8'h56);
        rd32chk(6, 32'h0, "R4 staged bytes not live");
        rdchk(3, 8'h00, "R11 load window reads zero");
        wr(2, 8'h78);
        rd32chk(6, 32'h56341278, "R4 commit value");
        rdchk(6, 8'h78, "R3 live byte 0");

        // R2 counting
        wr(0, 8'h80);
        tick(3);
        rd32chk(6, 32'h5634127B, "R2 three ticks");

        // R3 carry across bytes
        load32(32'h000000FF);
        tick(1);
        rd32chk(6, 32'h00000100, "R3 carry to byte 1");

        // R5 wrap without alarm flag
        setcmp(32'h5);
        wr(0, 8'h82);
        load32(32'hFFFFFFFF);
        tick(1);
        rd32chk(6, 32'h0, "R5 wrap to zero");
        rdchk(1, 8'h00, "R5 no flag on wrap");

        // R8 / R10 alarm match
        setcmp(32'h10);
        load32(32'h0E);
        tick(1);
        chk(alarm_irq == 1'b0, "R8 no early alarm", 32'(alarm_irq), 0);
        tick(1);
        chk(alarm_irq == 1'b1, "R10 irq on match", 32'(alarm_irq), 1);
        rdchk(1, 8'h01, "R8 status set");
        wr(0, 8'h80);
        chk(alarm_irq == 1'b0, "R10 irq gated by enable", 32'(alarm_irq), 0);
        rdchk(1, 8'h01, "R10 status kept");
        rdchk(0, 8'h80, "R6 ctrl bits independent");
        wr(1, 8'h01);
        rdchk(1, 8'h01, "R9 writing one ignored");
        wr(1, 8'h00);
        rdchk(1, 8'h00, "R9 status cleared");

        // R8 match with alarm disabled
        setcmp(32'h20);
        load32(32'h1F);
        tick(1);
        rdchk(1, 8'h00, "R8 no set while disabled");
        wr(0, 8'h82);
        chk(alarm_irq == 1'b0, "R8 no late irq", 32'(alarm_irq), 0);

        // R8 load onto compare value does not set
        load32(32'h20);
        rdchk(1, 8'h00, "R8 load no set");

        // R4 tick coincident with commit
        load32(32'hAABBCCDD, 1'b1);
        rd32chk(6, 32'hAABBCCDD, "R4 commit beats tick");

        // R9 set and clear in the same cycle
        load32(32'h1F);
        wr(1, 8'h00, 1'b1);
        rdchk(1, 8'h01, "R9 set wins over clear");
        chk(alarm_irq == 1'b1, "R10 irq after collision", 32'(alarm_irq), 1);
        wr(1, 8'h00);

        // R7 compare read/write
        setcmp(32'hCAFEF00D);
        rd32chk(10, 32'hCAFEF00D, "R7 compare readback");
        rdchk(10, 8'h0D, "R7 compare byte 0");
        setcmp(32'h0);
        rd32chk(10, 32'h0, "R7 compare cleared");

        // R11 and R6
        wr(0, 8'h00);
        load32(32'h01020304);
        wr(7, 8'hFF);
        rd32chk(6, 32'h01020304, "R11 live window write ignored");
        rdchk(14, 8'h00, "R11 unmapped 14");
        rdchk(15, 8'h00, "R11 unmapped 15");
        wr(0, 8'hFF);
        rdchk(0, 8'h82, "R6 unused ctrl bits zero");

        @(posedge clk); #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule